// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block turns three external interrupt pins into masked interrupt requests for a processor core. Each of the clock-sampled pins has its own 2-bit sense code, so it can report a held low level, any change of state, only falling edges or only rising edges. The remaining pin has no sampling path. Its edge, chosen by a one-bit polarity select, is caught by a storage element that the pin itself clocks, so a pulse much shorter than a clock period still leaves a mark. That mark is then carried into the clock domain.

Edge and toggle detections set sticky pending flags. The core clears a flag with a one-cycle acknowledge pulse or by a write-one-to-clear strobe. A low-level detection is not stored and lasts only while the pin stays low. A request leaves the block only when the source's mask bit and the global interrupt-enable input are both set. Sense codes, polarity and masks sit in a configuration register loaded by a write strobe. Software must clear a source's mask before changing its sense code, because the change itself can look like an event.

Top module: `ext_irq_sense`

## Requirements
- R1: After a synchronous reset, all pending flags, requests, sense codes, the polarity select and the mask bits are 0.
- R2: With sense code 00 (bits [2i+1:2i] of the code field for sampled source i), the pending flag is 1 while the synchronised pin is low and returns to 0 as soon as the pin is high again; nothing is held.
- R3: With sense code 01, either a rising or a falling change of the pin sets the pending flag.
- R4: With sense code 10, a falling edge sets the pending flag and a rising edge does not.
- R5: With sense code 11, a rising edge sets the pending flag and a falling edge does not.
- R6: In an edge mode, a pin pulse lasting two clock periods is never missed. The flag is set on the third rising clock edge after the pin changes, counting through two synchroniser stages and one history stage.
- R7: Request bit i is 1 exactly one cycle after pending bit i, mask bit i and the global enable are all 1, and is 0 one cycle after any of them is 0.
- R8: A one-cycle acknowledge or a write-one-to-clear strobe on a source clears its sticky flag. If a new edge is detected in the same cycle, the edge wins and the flag stays set.
- R9: The asynchronous source is index 2 of the mask, acknowledge, clear, pending and request vectors. With polarity select 1 it captures rising edges, and with 0 it captures falling edges. The opposite edge sets nothing.
- R10: On the asynchronous source, a pulse shorter than a clock period that falls wholly between two clock edges still sets the pending flag.
- R11: Acknowledging the asynchronous source clears its flag and its edge capture, and a later edge sets the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NS | Clock-sampled interrupt pins |
| apin_i | input | 1 | Asynchronously captured interrupt pin |
| cfg_we_i | input | 1 | Load strobe for the configuration register |
| cfg_code_i | input | 2*NS | Sense codes, two bits per sampled source |
| cfg_pol_i | input | 1 | Edge polarity of the asynchronous source (1 = rising) |
| cfg_mask_i | input | NS+1 | Per-source mask bits |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | NS+1 | One-cycle acknowledge per source |
| clr_i | input | NS+1 | Write-one-to-clear strobes per source |
| pend_o | output | NS+1 | Pending flags |
| req_o | output | NS+1 | Masked, registered interrupt requests |

## Verification
The bench builds the block with its defaults, two sampled sources and two synchroniser stages. With these values the same vector table can be applied to both sampled channels in turn, and the three-edge latency from pin to flag is a fixed number the bench can wait on exactly. With one asynchronous source at index 2, the bench can also drive sub-cycle pulses between clock edges and test edge-versus-acknowledge collisions in a known cycle.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    chain[0] <= d;
    for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
  end

  assign q = chain[LAST];
endmodule

// File: rtl/eirq_sampled_det.sv
module eirq_sampled_det
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   pin_i,
  input  sense_e code_i,
  input  logic   ack_i,
  input  logic   clr_i,
  output logic   pend_o
);
  logic s_now;
  logic s_prev;
  logic hit;
  logic pend_q;

  eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pin_i),
    .q   (s_now)
  );

  always_ff @(posedge clk) s_prev <= s_now;

  always_comb begin
    case (code_i)
      SENSE_ANY:  hit = s_now ^ s_prev;
      SENSE_FALL: hit = s_prev & ~s_now;
      SENSE_RISE: hit = s_now & ~s_prev;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                     pend_q <= 1'b0;
    else if (code_i == SENSE_LOW) pend_q <= ~s_now;
    else if (hit)                pend_q <= 1'b1;
    else if (ack_i || clr_i)     pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (code_i != SENSE_LOW && (ack_i || clr_i) && !hit) |=> !pend_o);

  // R2
  level_release_chk: assert property (@(posedge clk) disable iff (rst)
    (code_i == SENSE_LOW && s_now) |=> !pend_o);

  // R5
  rise_only_chk: assert property (@(posedge clk) disable iff (rst)
    (code_i == SENSE_RISE && !pend_o && !(s_now && !s_prev)) |=> !pend_o);
endmodule

// File: rtl/eirq_async_cap.sv
module eirq_async_cap #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic apin_i,
  input  logic pol_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic pend_o
);
  logic edge_clk;
  logic aclr_q;
  logic cap_q;
  logic cap_sync;
  logic cap_prev;
  logic rise;
  logic pend_q;

  // polarity 1 passes the pin, polarity 0 inverts it
  assign edge_clk = apin_i ~^ pol_i;

  always_ff @(posedge clk) aclr_q <= rst | ack_i | clr_i;

  always_ff @(posedge edge_clk or posedge aclr_q) begin
    if (aclr_q) cap_q <= 1'b0;
    else        cap_q <= 1'b1;
  end

  eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (cap_q),
    .q   (cap_sync)
  );

  always_ff @(posedge clk) cap_prev <= cap_sync;

  assign rise = cap_sync & ~cap_prev;

  always_ff @(posedge clk) begin
    if (rst)                 pend_q <= 1'b0;
    else if (rise)           pend_q <= 1'b1;
    else if (ack_i || clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R11
  async_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ((ack_i || clr_i) && !rise) |=> !pend_o);

  // R9
  async_set_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend_o && !rise) |=> !pend_o);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eirq_pkg::*;
#(
  parameter int NS          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NS-1:0]   pin_i,
  input  logic            apin_i,
  input  logic            cfg_we_i,
  input  logic [2*NS-1:0] cfg_code_i,
  input  logic            cfg_pol_i,
  input  logic [NS:0]     cfg_mask_i,
  input  logic            gie_i,
  input  logic [NS:0]     ack_i,
  input  logic [NS:0]     clr_i,
  output logic [NS:0]     pend_o,
  output logic [NS:0]     req_o
);
  localparam int NSRC = NS + 1;
  localparam int AIDX = NS;

  logic [2*NS-1:0] code_q;
  logic            pol_q;
  logic [NS:0]     mask_q;
  logic [NS:0]     pend;
  logic [NS:0]     req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      pol_q  <= 1'b0;
      mask_q <= '0;
    end else if (cfg_we_i) begin
      code_q <= cfg_code_i;
      pol_q  <= cfg_pol_i;
      mask_q <= cfg_mask_i;
    end
  end

  for (genvar i = 0; i < NS; i++) begin : g_samp
    eirq_sampled_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pin_i[i]),
      .code_i (sense_e'(code_q[2*i +: 2])),
      .ack_i  (ack_i[i]),
      .clr_i  (clr_i[i]),
      .pend_o (pend[i])
    );
  end

  eirq_async_cap #(.SYNC_STAGES(SYNC_STAGES)) u_async (
    .clk    (clk),
    .rst    (rst),
    .apin_i (apin_i),
    .pol_i  (pol_q),
    .ack_i  (ack_i[AIDX]),
    .clr_i  (clr_i[AIDX]),
    .pend_o (pend[AIDX])
  );

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= pend & mask_q & {NSRC{gie_i}};
  end

  assign pend_o = pend;
  assign req_o  = req_q;

  // R7
  gie_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> (req_o == '0));

  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> (req_o == '0));
endmodule

// File: tb/ext_irq_sense_tb_top.sv
module ext_irq_sense_tb_top;
  localparam int NS = 2;
  localparam int AI = NS;
  localparam time TCLK = 20ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0]   pin_i = '1;
  logic            apin_i = 1'b0;
  logic            cfg_we_i = 1'b0;
  logic [2*NS-1:0] cfg_code_i = '0;
  logic            cfg_pol_i = 1'b0;
  logic [NS:0]     cfg_mask_i = '0;
  logic            gie_i = 1'b0;
  logic [NS:0]     ack_i = '0;
  logic [NS:0]     clr_i = '0;
  logic [NS:0]     pend_o;
  logic [NS:0]     req_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  ext_irq_sense #(.NS(NS), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .pin_i(pin_i), .apin_i(apin_i),
    .cfg_we_i(cfg_we_i), .cfg_code_i(cfg_code_i), .cfg_pol_i(cfg_pol_i),
    .cfg_mask_i(cfg_mask_i), .gie_i(gie_i), .ack_i(ack_i), .clr_i(clr_i),
    .pend_o(pend_o), .req_o(req_o)
  );

  // {code[1:0], start level, end level, expected flag}
  localparam logic [4:0] VEC [8] = '{
    5'b00_1_0_1, 5'b00_0_1_0,
    5'b01_1_0_1, 5'b01_0_1_1,
    5'b10_1_0_1, 5'b10_0_1_0,
    5'b11_0_1_1, 5'b11_1_0_0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [2*NS-1:0] code, input logic pol, input logic [NS:0] mask);
    cfg_code_i = code; cfg_pol_i = pol; cfg_mask_i = mask; cfg_we_i = 1'b1;
    cyc(1);
    cfg_we_i = 1'b0;
  endtask

  task automatic pulse_clr(input int idx);
    clr_i[idx] = 1'b1;
    cyc(1);
    clr_i[idx] = 1'b0;
  endtask

  task automatic pulse_ack(input int idx);
    ack_i[idx] = 1'b1;
    cyc(1);
    ack_i[idx] = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(TCLK * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    cyc(5);
    // R1 checked while reset is still high and just after release
    check("R1 pend in reset", 32'(pend_o), 0);
    check("R1 req in reset", 32'(req_o), 0);
    rst = 1'b0;
    cyc(1);
    check("R1 req after reset", 32'(req_o), 0);
    check("R1 async pend after reset", 32'(pend_o[AI]), 0);

    // R2 R3 R4 R5 vector walk over both sampled sources
    for (int v = 0; v < 8; v++) begin
      automatic int ch = v % NS;
      automatic logic [1:0] code = VEC[v][4:3];
      cfg(4'(code) << (2*ch), 1'b0, '0);
      pin_i[ch] = VEC[v][2];
      cyc(4);
      pulse_clr(ch);
      cyc(1);
      pin_i[ch] = VEC[v][1];
      cyc(5);
      check($sformatf("R2-5 vec%0d code=%0b ch%0d", v, code, ch), 32'(pend_o[ch]), 32'(VEC[v][0]));
      pin_i = '1;
      cyc(4);
    end

    // R2 level mode: pin goes back high, flag drops without clear
    cfg(4'b0000, 1'b0, '0);
    pin_i[1] = 1'b0; cyc(5);
    check("R2 level low", 32'(pend_o[1]), 1);
    pin_i[1] = 1'b1; cyc(5);
    check("R2 level released", 32'(pend_o[1]), 0);

    // R6 two-cycle pulse, rising mode, exact latency
    cfg(4'b1111, 1'b0, '0);
    pin_i[0] = 1'b0; cyc(4); pulse_clr(0); cyc(1);
    pin_i[0] = 1'b1; cyc(2);
    check("R6 not yet at edge two", 32'(pend_o[0]), 0);
    pin_i[0] = 1'b0; cyc(1);
    check("R6 set at edge three", 32'(pend_o[0]), 1);
    cyc(4);
    check("R6 two-cycle pulse held", 32'(pend_o[0]), 1);

    // R7 gating
    gie_i = 1'b1;
    cfg(4'b1111, 1'b0, 3'b001);
    cyc(1);
    check("R7 req with mask and gie", 32'(req_o[0]), 1);
    gie_i = 1'b0; cyc(1);
    check("R7 req drops without gie", 32'(req_o[0]), 0);
    gie_i = 1'b1;
    cfg(4'b1111, 1'b0, 3'b000);
    cyc(1);
    check("R7 req drops without mask", 32'(req_o[0]), 0);

    // R8 acknowledge and write-one-to-clear
    pulse_ack(0); cyc(1);
    check("R8 ack clears", 32'(pend_o[0]), 0);
    pin_i[0] = 1'b1; cyc(5);
    check("R8 flag set again", 32'(pend_o[0]), 1);
    pulse_clr(0); cyc(1);
    check("R8 clear strobe clears", 32'(pend_o[0]), 0);
    // R8 edge detected in the same cycle as ack: edge wins
    pin_i[0] = 1'b0; cyc(4);
    pin_i[0] = 1'b1; cyc(2);
    ack_i[0] = 1'b1; cyc(1); ack_i[0] = 1'b0;
    cyc(1);
    check("R8 edge beats ack", 32'(pend_o[0]), 1);

    // R9 async polarity
    apin_i = 1'b0;
    cfg(4'b0000, 1'b1, '0);
    cyc(3); pulse_clr(AI); cyc(4);
    check("R9 async idle", 32'(pend_o[AI]), 0);
    apin_i = 1'b1; cyc(5);
    check("R9 rising captured pol1", 32'(pend_o[AI]), 1);
    pulse_clr(AI); cyc(4);
    apin_i = 1'b0; cyc(5);
    check("R9 falling ignored pol1", 32'(pend_o[AI]), 0);
    cfg(4'b0000, 1'b0, '0);
    cyc(3); pulse_clr(AI); cyc(4);
    apin_i = 1'b1; cyc(5);
    check("R9 rising ignored pol0", 32'(pend_o[AI]), 0);
    apin_i = 1'b0; cyc(5);
    check("R9 falling captured pol0", 32'(pend_o[AI]), 1);

    // R10 short pulse between clock edges
    cfg(4'b0000, 1'b1, '0);
    cyc(3); pulse_clr(AI); cyc(4);
    #2ns apin_i = 1'b1;
    #5ns apin_i = 1'b0;
    cyc(5);
    check("R10 short pulse captured", 32'(pend_o[AI]), 1);

    // R11 ack clears and re-arms the capture
    pulse_ack(AI); cyc(5);
    check("R11 ack clears async", 32'(pend_o[AI]), 0);
    apin_i = 1'b1; cyc(5);
    check("R11 next edge sets again", 32'(pend_o[AI]), 1);
    gie_i = 1'b1;
    cfg(4'b0000, 1'b1, 3'b100);
    cyc(1);
    check("R7 R9 async request", 32'(req_o[AI]), 1);

    finish_run();
  end
endmodule